// File: doc/BRIEF.md
# CAN Controller Interrupt Unit

This block sits between a CAN protocol engine and a host processor. The engine reports eight kinds of event, each as a one-cycle pulse. The block keeps one sticky flag per event and one enable bit per event, and it drives a single level-sensitive interrupt line. The line is high while any flag is set whose enable bit is also set.

The host reaches the block through a small register port with a two-bit address, a write strobe, write data and combinational read data. It reads the flags, acknowledges them by writing ones back to the bits it has handled, and programs the enable mask. Address 0 is the flag register and address 1 is the enable register. Address 2 is a read-only status word. Its bit 0 follows the receive-buffer-ready input and its bit 1 holds a latched data-overrun condition. That latch is cleared only by a dedicated command input, never by acknowledging the flag. Address 3 reads as zero.

Top module: `can_irq_unit`

## Requirements
- R1: After synchronous reset, the flag register, the enable register, the overrun latch and `irq_o` are all zero.
- R2: The flag bit set by each event line is fixed: bit 0 receive valid, bit 1 transmit complete, bit 2 error warning, bit 3 data overrun, bit 4 wakeup, bit 5 error passive, bit 6 arbitration lost, bit 7 bus error. A pulse on `evt_i[i]` sets flag bit i, and the new value is readable at address 0 after the next rising edge.
- R3: A flag is set by its event whatever the value of its enable bit.
- R4: Writing to address 0 clears each flag bit written as one. Bits written as zero keep their value.
- R5: If an event and a write-one clear reach the same flag bit in the same cycle, the flag ends up set.
- R6: A write to address 1 loads the enable register with the write data, and each bit can be set alone. For example, 0x7F enables every source except bus error. Address 1 reads back the stored value.
- R7: After every rising edge out of reset, `irq_o` equals the OR over all bits of (flag AND enable), computed from the register values that edge has just loaded.
- R8: Writing zero to the enable register drives `irq_o` low at the same edge that loads the enable register.
- R9: A pulse on `evt_i[3]` sets the overrun latch (status bit 1). Only `ovr_clr_i` clears it, and a set in the same cycle wins over the clear. Clearing flag bit 3 leaves the latch unchanged, and `ovr_clr_i` leaves flag bit 3 unchanged.
- R10: Reads have no side effects. Reading any address any number of times changes no state.
- R11: Address 2 reads {zeros, overrun latch, `rxbuf_rdy_i`}. Address 3 reads zero. Writes to addresses 2 and 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 8 | One-cycle event pulses from the protocol engine |
| rxbuf_rdy_i | input | 1 | Receive buffer holds a frame |
| ovr_clr_i | input | 1 | Command: clear the overrun latch |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i` (combinational) |
| irq_o | output | 1 | Level interrupt to the host |

## Verification
Two functions can meet in the same cycle: an engine event setting a flag, and a host write-one clear of that flag. The same kind of meeting happens between the overrun set and the overrun clear command. The bench provokes this on purpose with a directed collision on the error-warning bit. It also runs random cycles in which events, clears, enable writes and clear commands overlap freely. Every cycle is judged against a bench model in which set takes priority over clear, and the bench compares the read data for the addressed register and the interrupt line after each edge.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;

    localparam int NUM_EV   = 8;
    localparam int ADDR_W   = 2;

    // Event bit positions (the host decodes them)
    localparam int EV_RX_VALID  = 0;
    localparam int EV_TX_DONE   = 1;
    localparam int EV_ERR_WARN  = 2;
    localparam int EV_OVERRUN   = 3;
    localparam int EV_WAKE      = 4;
    localparam int EV_ERR_PASV  = 5;
    localparam int EV_ARB_LOST  = 6;
    localparam int EV_BUS_ERR   = 7;

    typedef logic [NUM_EV-1:0] ev_vec_t;

    typedef enum logic [ADDR_W-1:0] {
        REG_FLAG = 2'd0,
        REG_MASK = 2'd1,
        REG_STAT = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    // Sticky bit update: set has priority over clear
    function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
        return set | (cur & ~clr);
    endfunction

endpackage

// File: rtl/can_irq_flags.sv
module can_irq_flags
    import can_irq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  ev_vec_t set_i,
    input  ev_vec_t clr_i,
    output ev_vec_t flag_o,
    output ev_vec_t flag_next_o
);

    ev_vec_t flag_q;

    for (genvar i = 0; i < NUM_EV; i++) begin : g_bit
        assign flag_next_o[i] = sticky_next(flag_q[i], set_i[i], clr_i[i]);
        always_ff @(posedge clk) begin
            if (rst) flag_q[i] <= 1'b0;
            else     flag_q[i] <= flag_next_o[i];
        end
    end

    assign flag_o = flag_q;

    // Every pulsed event is present afterwards, even when also cleared
    assert_event_sets_R5: assert property (@(posedge clk) disable iff (rst)
        (set_i != '0) |=> ((flag_q & $past(set_i)) == $past(set_i)));

    // Cleared bits without a coinciding event are gone afterwards
    assert_w1c_clears_R4: assert property (@(posedge clk) disable iff (rst)
        ((clr_i & ~set_i) != '0) |=> ((flag_q & $past(clr_i & ~set_i)) == '0));

    // Bits neither set nor cleared hold their value
    assert_flag_hold_R10: assert property (@(posedge clk) disable iff (rst)
        ((set_i == '0) && (clr_i == '0)) |=> (flag_q == $past(flag_q)));

endmodule

// File: rtl/can_irq_mask.sv
module can_irq_mask
    import can_irq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    we_i,
    input  ev_vec_t wdata_i,
    output ev_vec_t mask_o,
    output ev_vec_t mask_next_o
);

    ev_vec_t mask_q;

    assign mask_next_o = we_i ? wdata_i : mask_q;

    always_ff @(posedge clk) begin
        if (rst) mask_q <= '0;
        else     mask_q <= mask_next_o;
    end

    assign mask_o = mask_q;

    assert_mask_load_R6: assert property (@(posedge clk) disable iff (rst)
        we_i |=> (mask_q == $past(wdata_i)));

    assert_mask_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !we_i |=> $stable(mask_q));

endmodule

// File: rtl/can_irq_ovr.sv
module can_irq_ovr (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_cmd_i,
    output logic ovr_o
);

    logic ovr_q;

    always_ff @(posedge clk) begin
        if (rst)            ovr_q <= 1'b0;
        else if (set_i)     ovr_q <= 1'b1;
        else if (clr_cmd_i) ovr_q <= 1'b0;
    end

    assign ovr_o = ovr_q;

    assert_ovr_set_R9: assert property (@(posedge clk) disable iff (rst)
        set_i |=> ovr_q);

    assert_ovr_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (clr_cmd_i && !set_i) |=> !ovr_q);

    assert_ovr_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!clr_cmd_i && !set_i) |=> $stable(ovr_q));

endmodule

// File: rtl/can_irq_unit.sv
module can_irq_unit
    import can_irq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  evt_i,
    input  logic        rxbuf_rdy_i,
    input  logic        ovr_clr_i,
    input  logic        bus_wr_i,
    input  logic [1:0]  bus_addr_i,
    input  logic [7:0]  bus_wdata_i,
    output logic [7:0]  bus_rdata_o,
    output logic        irq_o
);

    reg_sel_e sel;
    ev_vec_t  flag_clr;
    ev_vec_t  flags, flags_next;
    ev_vec_t  mask, mask_next;
    logic     mask_we;
    logic     ovr;
    logic     irq_q;

    assign sel      = reg_sel_e'(bus_addr_i);
    assign flag_clr = (bus_wr_i && sel == REG_FLAG) ? ev_vec_t'(bus_wdata_i) : '0;
    assign mask_we  = bus_wr_i && (sel == REG_MASK);

    can_irq_flags u_flags (
        .clk         (clk),
        .rst         (rst),
        .set_i       (ev_vec_t'(evt_i)),
        .clr_i       (flag_clr),
        .flag_o      (flags),
        .flag_next_o (flags_next)
    );

    can_irq_mask u_mask (
        .clk         (clk),
        .rst         (rst),
        .we_i        (mask_we),
        .wdata_i     (ev_vec_t'(bus_wdata_i)),
        .mask_o      (mask),
        .mask_next_o (mask_next)
    );

    can_irq_ovr u_ovr (
        .clk       (clk),
        .rst       (rst),
        .set_i     (evt_i[EV_OVERRUN]),
        .clr_cmd_i (ovr_clr_i),
        .ovr_o     (ovr)
    );

    // Registered from the next-state values so the line tracks the registers
    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |(flags_next & mask_next);
    end

    assign irq_o = irq_q;

    always_comb begin
        unique case (sel)
            REG_FLAG: bus_rdata_o = flags;
            REG_MASK: bus_rdata_o = mask;
            REG_STAT: bus_rdata_o = {{(NUM_EV-2){1'b0}}, ovr, rxbuf_rdy_i};
            default:  bus_rdata_o = '0;
        endcase
    end

    assert_irq_level_R7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_o == |(flags & mask)));

    assert_mask_zero_drops_irq_R8: assert property (@(posedge clk) disable iff (rst)
        (mask_we && bus_wdata_i == 8'h00) |=> !irq_o);

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (flags == '0 && mask == '0 && !ovr && !irq_o));

endmodule

// File: tb/can_irq_unit_bench.sv
module can_irq_unit_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] evt;
    logic       rxb;
    logic       oclr;
    logic       wr;
    logic [1:0] addr;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic       irq;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    // Bench model
    logic [7:0] m_flag, m_mask;
    logic       m_ovr, m_irq;

    always #5 clk = ~clk;

    can_irq_unit u_can_irq_unit (
        .clk         (clk),
        .rst         (rst),
        .evt_i       (evt),
        .rxbuf_rdy_i (rxb),
        .ovr_clr_i   (oclr),
        .bus_wr_i    (wr),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    function automatic logic [7:0] exp_read(input logic [1:0] a, input logic rx);
        case (a)
            2'd0:    return m_flag;
            2'd1:    return m_mask;
            2'd2:    return {6'b0, m_ovr, rx};
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // One clock cycle of stimulus, then model update and comparison
    task automatic cyc(input string tag, input logic [7:0] e, input logic w,
                       input logic [1:0] a, input logic [7:0] d,
                       input logic c, input logic r);
        logic [7:0] clr;
        @(negedge clk);
        evt = e; wr = w; addr = a; wdata = d; oclr = c; rxb = r;
        @(posedge clk);
        #1;
        clr    = (w && a == 2'd0) ? d : 8'h00;
        m_flag = (m_flag & ~clr) | e;
        if (w && a == 2'd1) m_mask = d;
        if (e[3])      m_ovr = 1'b1;
        else if (c)    m_ovr = 1'b0;
        m_irq  = |(m_flag & m_mask);
        check({tag, " rdata"}, rdata, exp_read(a, r));
        check({tag, " irq"}, {7'b0, irq}, {7'b0, m_irq});
        @(negedge clk);
        evt = '0; wr = 1'b0; oclr = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [1:0] a);
        cyc(tag, 8'h00, 1'b0, a, 8'h00, 1'b0, rxb);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] e, d;
        logic [1:0] a;
        logic       w, c, r;
        int unsigned seed;
        seed = 32'd1357;
        void'($urandom(seed));
        rst = 1'b1; evt = '0; rxb = 1'b0; oclr = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
        m_flag = '0; m_mask = '0; m_ovr = 1'b0; m_irq = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset values
        rd("R1 flags", 2'd0);
        rd("R1 mask", 2'd1);
        rd("R1 status", 2'd2);

        // R2, R3: each event line sets its own bit, enables off
        for (int i = 0; i < 8; i++) begin
            cyc("R2 R3 event bit", 8'(1 << i), 1'b0, 2'd0, 8'h00, 1'b0, 1'b0);
            cyc("R4 ack", 8'h00, 1'b1, 2'd0, 8'(1 << i), 1'b0, 1'b0);
        end

        // R4: partial clear, zero write keeps
        cyc("R4 fill", 8'hFF, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0);
        cyc("R4 partial w1c", 8'h00, 1'b1, 2'd0, 8'h0F, 1'b0, 1'b0);
        cyc("R4 zero write", 8'h00, 1'b1, 2'd0, 8'h00, 1'b0, 1'b0);
        cyc("R4 clear rest", 8'h00, 1'b1, 2'd0, 8'hFF, 1'b1, 1'b0);

        // R5: set and clear collide on error warning bit
        cyc("R5 set wins", 8'h04, 1'b1, 2'd0, 8'h04, 1'b0, 1'b0);
        cyc("R5 later clear", 8'h00, 1'b1, 2'd0, 8'h04, 1'b0, 1'b0);

        // R6, R7: all but bus error enabled
        cyc("R6 mask 7F", 8'h00, 1'b1, 2'd1, 8'h7F, 1'b0, 1'b0);
        cyc("R7 bus err masked", 8'h80, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0);
        cyc("R7 rx valid raises", 8'h01, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0);
        cyc("R6 single bit mask", 8'h00, 1'b1, 2'd1, 8'h80, 1'b0, 1'b0);

        // R8: zero mask drops irq at once
        cyc("R8 mask zero", 8'h00, 1'b1, 2'd1, 8'h00, 1'b0, 1'b0);
        cyc("R8 clear flags", 8'h00, 1'b1, 2'd0, 8'hFF, 1'b0, 1'b0);

        // R9: overrun latch path is separate
        cyc("R9 overrun event", 8'h08, 1'b0, 2'd2, 8'h00, 1'b0, 1'b0);
        cyc("R9 w1c flag keeps latch", 8'h00, 1'b1, 2'd0, 8'h08, 1'b0, 1'b0);
        rd("R9 latch still set", 2'd2);
        cyc("R9 set beats cmd", 8'h08, 1'b0, 2'd2, 8'h00, 1'b1, 1'b0);
        cyc("R9 cmd clears latch", 8'h00, 1'b0, 2'd2, 8'h00, 1'b1, 1'b0);
        rd("R9 cmd keeps flag", 2'd0);

        // R10: repeated reads change nothing
        for (int i = 0; i < 4; i++) rd("R10 reread flags", 2'd0);

        // R11: status and unused address
        cyc("R11 rx ready", 8'h00, 1'b0, 2'd2, 8'h00, 1'b0, 1'b1);
        cyc("R11 write status ignored", 8'h00, 1'b1, 2'd2, 8'hFF, 1'b0, 1'b0);
        cyc("R11 write addr3 ignored", 8'h00, 1'b1, 2'd3, 8'hFF, 1'b0, 1'b0);
        rd("R11 mask unchanged", 2'd1);
        rd("R11 flags unchanged", 2'd0);

        // Random mix (R4 R5 R7 R9)
        for (int k = 0; k < 400; k++) begin
            e = ($urandom % 3 == 0) ? 8'($urandom) & 8'($urandom) : 8'h00;
            w = ($urandom % 2) == 1;
            a = 2'($urandom);
            d = 8'($urandom);
            c = ($urandom % 5) == 0;
            r = ($urandom % 2) == 1;
            cyc("R7 random", e, w, a, d, c, r);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule